// File: doc/BRIEF.md
# Suspend Modulation Duty Controller

This block slows a processor down by pulsing an active-low suspend line. While the line is low the processor idles. The line is low for a programmed number of time units and then high for another programmed number, and this pattern repeats for as long as modulation is enabled. One time unit is nominally 32 µs. The useful processor rate is the full rate scaled by HIGH / (HIGH + LOW). Here LOW is the low-count register and HIGH is the high-count register.

Software sets the block up through a byte-wide register port. The port has a synchronous write and a combinational read. Two activity inputs, one for interrupts and one for video, can each restart a millisecond timer. While either timer is running, the suspend line is forced high and the phase sequencer is frozen. A fixed prescaler inside the block turns the clock into unit ticks and millisecond ticks.

The register map is as follows:

| Address | Register | Meaning |
|---|---|---|
| 0 | release count | HIGH count |
| 1 | hold count | LOW count |
| 2 | control | bit 0 enables modulation |
| 3 | power enable | bit 0 is the master enable, bit 3 lets interrupt activity trigger its timer, bit 4 lets video activity trigger its timer |
| 4 | interrupt speedup duration | in ms |
| 5 | video speedup duration | in ms |
| 6, 7 | none | read as zero |

Top module: `susp_duty_ctrl`

## Requirements
- R1: After reset, every register reads 0 and susp_n is 1.
- R2: A write to address 0 to 5 stores the whole byte, and a read returns it in the same cycle. Addresses 6 and 7 read 0 even after a write.
- R3: Modulation runs when control bit 0 and power-enable bit 0 are both 1. While it runs, susp_n repeats a pattern of exactly LOW×CLK_PER_UNIT cycles low followed by HIGH×CLK_PER_UNIT cycles high.
- R4: If control bit 0 is 0, or power-enable bit 0 is 0, susp_n stays 1.
- R5: If the low count is 0, susp_n never goes low.
- R6: If the high count is 0 and the low count is nonzero, susp_n stays low continuously while modulation runs.
- R7: A count written in the middle of a phase does not change that phase. The new value first applies to the next phase of that kind.
- R8: A one-cycle interrupt event starts the interrupt timer when power-enable bit 3 is 1 and its duration D is nonzero. susp_n then stays 1 for more than (D−1) ms and at most D ms. The phase sequencer does not advance during this time, and modulation resumes afterwards.
- R9: Video events, power-enable bit 4 and the video duration register behave as in R8.
- R10: A new qualifying event restarts its timer at the full duration.
- R11: An event whose enable bit is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend to the processor |

## Verification
A register write lands on the next clock edge. The enable bits take effect on susp_n in that same cycle, because the output is decoded from registered state. Phase edges always fall on unit ticks, whose position in time is unknown to the bench. The bench therefore does not predict absolute edge times: it waits for a clean edge, counts the run lengths of susp_n at negative edges, and compares them with counts×CLK_PER_UNIT. Speedup holds resolve only to the millisecond tick, so those checks use a window: susp_n must stay high for (D−1) ms after the load edge, and must go low again within D ms plus one full period.

// File: rtl/susp_pkg.sv
`timescale 1ns/1ps
package susp_pkg;
    localparam int ADDR_W = 3;
    localparam int CFG_EN    = 0;
    localparam int PM_GLOBAL = 0;
    localparam int PM_IRQ    = 3;
    localparam int PM_VID    = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_OFF  = 3'd0,
        A_ON   = 3'd1,
        A_CFG  = 3'd2,
        A_PMEN = 3'd3,
        A_IRQT = 3'd4,
        A_VIDT = 3'd5
    } reg_addr_e;

    typedef enum logic {PH_ON = 1'b0, PH_OFF = 1'b1} phase_e;

    typedef struct packed {
        logic [7:0] off_cnt;
        logic [7:0] on_cnt;
        logic [7:0] cfg;
        logic [7:0] pmen;
        logic [7:0] irq_dur;
        logic [7:0] vid_dur;
    } regs_t;
endpackage

// File: rtl/susp_regs.sv
`timescale 1ns/1ps
module susp_regs
    import susp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output regs_t             regs
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                A_OFF:   regs_d.off_cnt = wdata;
                A_ON:    regs_d.on_cnt  = wdata;
                A_CFG:   regs_d.cfg     = wdata;
                A_PMEN:  regs_d.pmen    = wdata;
                A_IRQT:  regs_d.irq_dur = wdata;
                A_VIDT:  regs_d.vid_dur = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_OFF:   rdata = regs_q.off_cnt;
            A_ON:    rdata = regs_q.on_cnt;
            A_CFG:   rdata = regs_q.cfg;
            A_PMEN:  rdata = regs_q.pmen;
            A_IRQT:  rdata = regs_q.irq_dur;
            A_VIDT:  rdata = regs_q.vid_dur;
            default: rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_ON) |=> (regs_q.on_cnt == $past(wdata))); // R2
endmodule

// File: rtl/susp_tick.sv
`timescale 1ns/1ps
module susp_tick #(
    parameter int CLK_PER_UNIT = 1600,
    parameter int UNITS_PER_MS = 31
) (
    input  logic clk,
    input  logic rst_n,
    output logic unit_tick,
    output logic ms_tick
);
    localparam int PRE_W = (CLK_PER_UNIT > 1) ? $clog2(CLK_PER_UNIT) : 1;
    localparam int MSC_W = (UNITS_PER_MS > 1) ? $clog2(UNITS_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_UNIT - 1);
    localparam logic [MSC_W-1:0] MSC_LAST = MSC_W'(UNITS_PER_MS - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [MSC_W-1:0] msc;
        logic             unit;
        logic             ms;
    } tick_t;

    tick_t d, q;

    always_comb begin
        d = q;
        d.unit = 1'b0;
        d.ms   = 1'b0;
        if (q.pre == PRE_LAST) begin
            d.pre  = '0;
            d.unit = 1'b1;
            if (q.msc == MSC_LAST) begin
                d.msc = '0;
                d.ms  = 1'b1;
            end else begin
                d.msc = q.msc + 1'b1;
            end
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign unit_tick = q.unit;
    assign ms_tick   = q.ms;

    AST_MS_ON_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |-> unit_tick); // R8
endmodule

// File: rtl/susp_speedup.sv
`timescale 1ns/1ps
module susp_speedup (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic       en,
    input  logic [7:0] dur,
    input  logic       ms_tick,
    output logic       hold
);
    typedef struct packed {
        logic [7:0] tmr;
    } spd_t;

    spd_t d, q;

    always_comb begin
        d = q;
        if (evt && en)
            d.tmr = dur;
        else if (ms_tick && q.tmr != 8'd0)
            d.tmr = q.tmr - 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold = (q.tmr != 8'd0);

    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && en) |=> (q.tmr == $past(dur))); // R10
    AST_TMR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !en && q.tmr == 8'd0) |=> (q.tmr == 8'd0)); // R11
endmodule

// File: rtl/susp_phase.sv
`timescale 1ns/1ps
module susp_phase
    import susp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       hold,
    input  logic       unit_tick,
    input  logic [7:0] on_reg,
    input  logic [7:0] off_reg,
    output logic       susp_act
);
    typedef struct packed {
        phase_e     ph;
        logic [7:0] cnt;
        logic [7:0] on_len;
        logic [7:0] off_len;
    } ph_t;

    ph_t d, q;
    logic [7:0] cur_len;
    logic       boundary;

    always_comb begin
        d = q;
        cur_len  = (q.ph == PH_ON) ? q.on_len : q.off_len;
        boundary = (cur_len == 8'd0) ||
                   (({1'b0, q.cnt} + 9'd1) >= {1'b0, cur_len});
        if (!run) begin
            d.ph      = PH_ON;
            d.cnt     = 8'd0;
            d.on_len  = on_reg;
            d.off_len = off_reg;
        end else if (!hold && unit_tick) begin
            if (boundary) begin
                d.cnt     = 8'd0;
                d.on_len  = on_reg;
                d.off_len = off_reg;
                if (q.ph == PH_ON)
                    d.ph = (off_reg != 8'd0) ? PH_OFF :
                           ((on_reg != 8'd0) ? PH_ON : PH_OFF);
                else
                    d.ph = (on_reg != 8'd0) ? PH_ON : PH_OFF;
            end else begin
                d.cnt = q.cnt + 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_ON, cnt: 8'd0, on_len: 8'd0, off_len: 8'd0};
        else        q <= d;
    end

    assign susp_act = run && !hold && (q.ph == PH_ON) && (q.on_len != 8'd0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.ph == PH_ON && q.on_len != 8'd0) |-> (q.cnt < q.on_len)); // R3
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold) |=> (!run || q.cnt == $past(q.cnt))); // R8
    AST_LEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !unit_tick) |=> (!run || q.on_len == $past(q.on_len))); // R7
endmodule

// File: rtl/susp_duty_ctrl.sv
`timescale 1ns/1ps
module susp_duty_ctrl
    import susp_pkg::*;
#(
    parameter int CLK_PER_UNIT = 1600,
    parameter int UNITS_PER_MS = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);
    regs_t regs;
    logic  unit_tick, ms_tick;
    logic  irq_hold, vid_hold, run, susp_act;
    logic  unused_bits;

    susp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .regs(regs)
    );

    susp_tick #(.CLK_PER_UNIT(CLK_PER_UNIT), .UNITS_PER_MS(UNITS_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .ms_tick(ms_tick)
    );

    susp_speedup u_irq_spd (
        .clk(clk), .rst_n(rst_n), .evt(irq_evt), .en(regs.pmen[PM_IRQ]),
        .dur(regs.irq_dur), .ms_tick(ms_tick), .hold(irq_hold)
    );

    susp_speedup u_vid_spd (
        .clk(clk), .rst_n(rst_n), .evt(vid_evt), .en(regs.pmen[PM_VID]),
        .dur(regs.vid_dur), .ms_tick(ms_tick), .hold(vid_hold)
    );

    assign run = regs.cfg[CFG_EN] && regs.pmen[PM_GLOBAL];

    susp_phase u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .hold(irq_hold || vid_hold),
        .unit_tick(unit_tick), .on_reg(regs.on_cnt), .off_reg(regs.off_cnt),
        .susp_act(susp_act)
    );

    assign susp_n = !susp_act;
    assign unused_bits = ^{regs.cfg[7:1], regs.pmen[7:5], regs.pmen[2:1]};

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(regs.cfg[CFG_EN] && regs.pmen[PM_GLOBAL]) |-> susp_n); // R4
    AST_SPEEDUP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hold || vid_hold) |-> susp_n); // R8
    AST_ZERO_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.on_cnt == 8'd0 && $stable(regs.on_cnt) && !run) |=> susp_n); // R5
endmodule

// File: tb/susp_duty_ctrl_tb_top.sv
`timescale 1ns/1ps
module susp_duty_ctrl_tb_top;
    localparam int CPU = 4;
    localparam int UPM = 5;
    localparam int MS  = CPU * UPM;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    susp_duty_ctrl #(.CLK_PER_UNIT(CPU), .UNITS_PER_MS(UPM)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_evt(irq_evt),
        .vid_evt(vid_evt), .susp_n(susp_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_level(input logic lv, output int waited);
        waited = 0;
        while (susp_n != lv && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic run_len(output int n);
        logic lv;
        lv = susp_n;
        n = 0;
        while (susp_n == lv && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_low(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            if (!susp_n) lows++;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input bit vid);
        if (vid) vid_evt = 1'b1; else irq_evt = 1'b1;
        @(negedge clk);
        vid_evt = 1'b0; irq_evt = 1'b0;
    endtask

    task automatic setup(input int on_c, input int off_c, input logic [7:0] pm);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'(on_c));
        wr(3'd0, 8'(off_c));
        wr(3'd3, pm);
        wr(3'd2, 8'h01);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int w, h, l, lows, t;
        repeat (3) @(negedge clk);
        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg", int'(v), 0);
        end
        chk("R1 susp_n", int'(susp_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 susp_n after release", int'(susp_n), 1);

        // R2: register write/readback
        for (int a = 0; a < 8; a++) begin
            wr(3'(a), 8'(8'hA5 ^ (a * 37)));
        end
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R2 readback", int'(v), (a < 6) ? int'(8'(8'hA5 ^ (a * 37))) : 0);
        end
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);

        // R3: sweep low/high counts
        for (int on_c = 1; on_c <= 4; on_c++) begin
            for (int off_c = 1; off_c <= 4; off_c++) begin
                setup(on_c, off_c, 8'h01);
                wait_level(1'b0, w);
                wait_level(1'b1, w);
                run_len(h);
                chk("R3 high run", h, off_c * CPU);
                run_len(l);
                chk("R3 low run", l, on_c * CPU);
            end
        end

        // R4: either enable clear keeps susp_n high
        setup(2, 2, 8'h01);
        wr(3'd2, 8'h00);
        count_low(60, lows);
        chk("R4 control off", lows, 0);
        setup(2, 2, 8'h00);
        count_low(60, lows);
        chk("R4 master off", lows, 0);

        // R5: zero low count
        setup(0, 3, 8'h01);
        count_low(120, lows);
        chk("R5 zero low count", lows, 0);

        // R6: zero high count
        setup(2, 0, 8'h01);
        repeat (12) @(negedge clk);
        count_low(120, lows);
        chk("R6 zero high count", lows, 120);

        // R7: mid-phase update waits for next boundary
        setup(3, 2, 8'h01);
        wait_level(1'b0, w);
        wait_level(1'b1, w);
        wait_level(1'b0, w);
        wr(3'd1, 8'd1);
        run_len(l);
        chk("R7 current low kept", l + 1, 3 * CPU);
        run_len(h);
        chk("R7 high run", h, 2 * CPU);
        run_len(l);
        chk("R7 new low applied", l, 1 * CPU);

        // R8: interrupt speedup hold
        wr(3'd4, 8'd3);
        setup(2, 2, 8'h09);
        repeat (20) @(negedge clk);
        pulse(1'b0);
        count_low(2 * MS - 1, lows);
        chk("R8 irq hold high", lows, 0);
        wait_level(1'b0, w);
        chk("R8 resume", int'(w < MS + 16), 1);

        // R10: retrigger restarts
        repeat (5) @(negedge clk);
        pulse(1'b0);
        repeat (30) @(negedge clk);
        pulse(1'b0);
        count_low(2 * MS - 1, lows);
        chk("R10 retrigger hold", lows, 0);
        wait_level(1'b0, w);
        chk("R10 resume", int'(w < MS + 16), 1);

        // R11: interrupt event ignored when its enable is clear
        wr(3'd3, 8'h01);
        wait_level(1'b1, w);
        pulse(1'b0);
        t = 0;
        while (susp_n && t < 40) begin
            @(negedge clk);
            t++;
        end
        chk("R11 irq ignored", int'(t < 2 * 2 * CPU + 2), 1);

        // R9: video speedup hold
        wr(3'd5, 8'd2);
        wr(3'd3, 8'h11);
        repeat (10) @(negedge clk);
        pulse(1'b1);
        count_low(MS - 1, lows);
        chk("R9 video hold high", lows, 0);
        wait_level(1'b0, w);
        chk("R9 resume", int'(w < MS + 16), 1);

        // R11: video event ignored when its enable is clear
        wr(3'd3, 8'h09);
        wait_level(1'b1, w);
        pulse(1'b1);
        t = 0;
        while (susp_n && t < 40) begin
            @(negedge clk);
            t++;
        end
        chk("R11 video ignored", int'(t < 2 * 2 * CPU + 2), 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule